// File: doc/BRIEF.md
# Flash Bypass-Mode Program Sequencer

This block writes a run of words from a host-side data stream into a parallel NOR flash. It uses the flash's unlock-bypass mode. After a start pulse with a base address and a word count, it issues the three-write bypass entry. For each word it then takes one word from the valid/ready stream and issues a two-write program pair: a command write followed by the address and data write. Between words it waits for the device's ready/busy line to fall and then rise again. After the last word it leaves bypass mode with a two-write exit and pulses a done flag.

Each bus write is a fixed-length strobe. The address and data settle one clock before the write strobe falls and stay unchanged for one clock after it rises. The target address increments by one per word, with no sector boundary logic. The device's program-failure flag or a stuck busy line ends the run early. In that case the block aborts the remaining words, writes the reset command, raises an error and holds the address of the word that failed.

Top module: `flash_prog_seq`

## Requirements
- R1: After start_i is accepted, the first three bus writes are (address 555h, data AAh), (address 2AAh, data 55h), (address 555h, data 20h).
- R2: Word i of a run is programmed as a write of data A0h followed by a write of the i-th stream word to address base_addr_i + i. Addresses increment by one across any boundary.
- R3: Every bus write holds fl_we_no low for exactly WE_LOW_CYC clocks. fl_addr_o and fl_dq_o are unchanged from one clock before the falling edge of fl_we_no until one clock after its rising edge.
- R4: After the data write of a word, no further write other than the reset command is issued until fl_ready_i has gone low and then high again.
- R5: After the last word, the block writes 90h and then 00h. done_o is then high for exactly one clock, in the clock that follows the rise of fl_we_no on the 00h write.
- R6: A start with count_i = 0 produces only the three entry writes and the two exit writes, and then pulses done_o.
- R7: When fl_fail_i is seen high while the block waits on a word, it issues no further program writes and writes F0h. It then raises error_o with err_tmo_o low and err_addr_o equal to the failing word's address, and done_o stays low.
- R8: When fl_ready_i does not complete its low-then-high cycle within TMO_CYC clocks of waiting, the block behaves as in R7 but with err_tmo_o high.
- R9: wready_o is high only while the block waits for the next word. A word is taken on a clock where wvalid_i and wready_o are both high, and stalls on wvalid_i delay the run without changing its writes.
- R10: start_i has no effect while busy_o is high. The write sequence of the current run is unchanged.
- R11: After reset, fl_we_no is high and busy_o, done_o, error_o and wready_o are low.
- R12: error_o is cleared when a new run is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run (sampled while idle) |
| base_addr_i | input | AW | First target word address |
| count_i | input | CW | Number of words in the run |
| wdata_i | input | DW | Stream word |
| wvalid_i | input | 1 | Stream word valid |
| wready_o | output | 1 | Block ready for the next word |
| fl_addr_o | output | AW | Flash address |
| fl_dq_o | output | DW | Flash write data |
| fl_we_no | output | 1 | Flash write strobe, active low |
| fl_ready_i | input | 1 | Flash ready/busy line, high when ready |
| fl_fail_i | input | 1 | Flash program-failure flag |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-clock pulse at the end of a clean run |
| error_o | output | 1 | Last run ended on failure or timeout |
| err_tmo_o | output | 1 | Error was caused by a timeout |
| err_addr_o | output | AW | Address of the word that failed |

## Verification
A write takes one idle clock, one setup clock, WE_LOW_CYC strobe clocks and one hold clock. The bench samples on the falling clock edge and logs each write at the sample where fl_we_no is first seen high again. It checks setup stability at the sample where the strobe is first low, and hold stability at the sample after the write is logged. done_o must appear at exactly the sample after the exit write is logged and must be gone by the following one. Device busy windows are driven by a bench model that lowers fl_ready_i two samples after each data write, so that R4 and the timeout are tested against cycle counts known in advance.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [7:0] CMD_UNLK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B = 8'h55;
  localparam logic [7:0] CMD_BYP_ON = 8'h20;
  localparam logic [7:0] CMD_PGM    = 8'hA0;
  localparam logic [7:0] CMD_BYP_X1 = 8'h90;
  localparam logic [7:0] CMD_BYP_X2 = 8'h00;
  localparam logic [7:0] CMD_RESET  = 8'hF0;

  typedef enum logic [3:0] {
    S_IDLE, S_ENT1, S_ENT2, S_ENT3, S_FETCH, S_PCMD,
    S_PDATA, S_WAIT, S_EXIT1, S_EXIT2, S_RST
  } seq_state_e;

  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_LOW, P_HOLD} wr_phase_e;
endpackage

// File: rtl/flash_bus_wr.sv
module flash_bus_wr
  import flash_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int LOW_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          we_no
);
  localparam int LW = $clog2(LOW_CYC + 1);

  wr_phase_e     ph_q;
  logic [LW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= P_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      we_q   <= 1'b1;
    end else begin
      case (ph_q)
        P_IDLE: if (go_i) begin
          addr_q <= addr_i;
          data_q <= data_i;
          ph_q   <= P_SETUP;
        end
        P_SETUP: begin
          we_q  <= 1'b0;
          cnt_q <= LW'(LOW_CYC - 1);
          ph_q  <= P_LOW;
        end
        P_LOW: begin
          if (cnt_q == '0) begin
            we_q <= 1'b1;
            ph_q <= P_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ph_q <= P_IDLE;
      endcase
    end
  end

  assign idle_o = (ph_q == P_IDLE);
  assign done_o = (ph_q == P_HOLD);
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign we_no  = we_q;

  AST_SETUP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no) |-> ($stable(addr_o) && $stable(data_o))); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |=> ($stable(addr_o) && $stable(data_o))); // R3
endmodule

// File: rtl/flash_rdy_mon.sv
module flash_rdy_mon #(
  parameter int TMO_CYC = 1000,
  parameter int SYNC_N  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic ready_i,
  input  logic fail_i,
  output logic ok_o,
  output logic fail_o,
  output logic tmo_o
);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic [SYNC_N:0] rdy_p, fl_p;
  assign rdy_p[0] = ready_i;
  assign fl_p[0]  = fail_i;

  for (genvar g = 0; g < SYNC_N; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdy_p[g+1] <= 1'b1;
        fl_p[g+1]  <= 1'b0;
      end else begin
        rdy_p[g+1] <= rdy_p[g];
        fl_p[g+1]  <= fl_p[g];
      end
    end
  end

  logic          rdy_s, fail_s, seen_q;
  logic [TW-1:0] cnt_q;
  assign rdy_s  = rdy_p[SYNC_N];
  assign fail_s = fl_p[SYNC_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!arm_i) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (!rdy_s) seen_q <= 1'b1;
      if (cnt_q != TW'(TMO_CYC)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ok_o   = arm_i && seen_q && rdy_s && !fail_s;
  assign fail_o = arm_i && fail_s;
  assign tmo_o  = arm_i && (cnt_q == TW'(TMO_CYC));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int WE_LOW_CYC = 3,
  parameter int TMO_CYC = 1000,
  parameter int SYNC_N = 2,
  parameter logic [AW-1:0] UNLK_ADDR1 = AW'('h555),
  parameter logic [AW-1:0] UNLK_ADDR2 = AW'('h2AA)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wvalid_i,
  output logic          wready_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_we_no,
  input  logic          fl_ready_i,
  input  logic          fl_fail_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o,
  output logic          err_tmo_o,
  output logic [AW-1:0] err_addr_o
);
  seq_state_e    st_q;
  logic [AW-1:0] cur_addr_q, err_addr_q;
  logic [CW-1:0] remain_q;
  logic [DW-1:0] wbuf_q;
  logic          done_q, err_q, tmo_q;

  logic          wr_op, wr_go, wr_idle, wr_done;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          mon_ok, mon_fail, mon_tmo;

  always_comb begin
    wr_op   = 1'b1;
    wr_addr = cur_addr_q;
    wr_data = '0;
    case (st_q)
      S_ENT1:  begin wr_addr = UNLK_ADDR1; wr_data = DW'(CMD_UNLK_A); end
      S_ENT2:  begin wr_addr = UNLK_ADDR2; wr_data = DW'(CMD_UNLK_B); end
      S_ENT3:  begin wr_addr = UNLK_ADDR1; wr_data = DW'(CMD_BYP_ON); end
      S_PCMD:  wr_data = DW'(CMD_PGM);
      S_PDATA: wr_data = wbuf_q;
      S_EXIT1: wr_data = DW'(CMD_BYP_X1);
      S_EXIT2: wr_data = DW'(CMD_BYP_X2);
      S_RST:   wr_data = DW'(CMD_RESET);
      default: wr_op = 1'b0;
    endcase
  end
  assign wr_go = wr_op && wr_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      cur_addr_q <= '0;
      err_addr_q <= '0;
      remain_q   <= '0;
      wbuf_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      tmo_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          cur_addr_q <= base_addr_i;
          remain_q   <= count_i;
          err_q      <= 1'b0;
          tmo_q      <= 1'b0;
          st_q       <= S_ENT1;
        end
        S_ENT1: if (wr_done) st_q <= S_ENT2;
        S_ENT2: if (wr_done) st_q <= S_ENT3;
        S_ENT3: if (wr_done) st_q <= (remain_q == '0) ? S_EXIT1 : S_FETCH;
        S_FETCH: if (wvalid_i) begin
          wbuf_q <= wdata_i;
          st_q   <= S_PCMD;
        end
        S_PCMD:  if (wr_done) st_q <= S_PDATA;
        S_PDATA: if (wr_done) st_q <= S_WAIT;
        S_WAIT: begin
          if (mon_fail || mon_tmo) begin
            err_addr_q <= cur_addr_q;
            tmo_q      <= !mon_fail;
            st_q       <= S_RST;
          end else if (mon_ok) begin
            cur_addr_q <= cur_addr_q + 1'b1;
            remain_q   <= remain_q - 1'b1;
            st_q       <= (remain_q == CW'(1)) ? S_EXIT1 : S_FETCH;
          end
        end
        S_EXIT1: if (wr_done) st_q <= S_EXIT2;
        S_EXIT2: if (wr_done) begin
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        S_RST: if (wr_done) begin
          err_q <= 1'b1;
          st_q  <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  flash_bus_wr #(.AW(AW), .DW(DW), .LOW_CYC(WE_LOW_CYC)) u_wr (
    .clk_i, .rst_ni,
    .go_i   (wr_go),
    .addr_i (wr_addr),
    .data_i (wr_data),
    .idle_o (wr_idle),
    .done_o (wr_done),
    .addr_o (fl_addr_o),
    .data_o (fl_dq_o),
    .we_no  (fl_we_no)
  );

  flash_rdy_mon #(.TMO_CYC(TMO_CYC), .SYNC_N(SYNC_N)) u_mon (
    .clk_i, .rst_ni,
    .arm_i   (st_q == S_WAIT),
    .ready_i (fl_ready_i),
    .fail_i  (fl_fail_i),
    .ok_o    (mon_ok),
    .fail_o  (mon_fail),
    .tmo_o   (mon_tmo)
  );

  assign wready_o   = (st_q == S_FETCH);
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
  assign error_o    = err_q;
  assign err_tmo_o  = tmo_q;
  assign err_addr_o = err_addr_q;

  AST_DONE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_NOT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !error_o); // R7
  AST_ERR_AFTER_RESET_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> (fl_dq_o == DW'(CMD_RESET))); // R7
  AST_FETCH_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wready_o |-> fl_we_no); // R9
endmodule

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20, DW = 16, CW = 16;
  localparam int WE_LOW = 3;
  localparam int TMO = 80;
  localparam int BUSY_CYC = 6;
  localparam int MAXLOG = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [CW-1:0] count = '0;
  logic [DW-1:0] wdata = '0;
  logic wvalid = 1'b0;
  logic wready, we_n, busy, done, error, err_tmo;
  logic [AW-1:0] fl_addr, err_addr;
  logic [DW-1:0] fl_dq;
  logic fl_ready = 1'b1, fl_fail = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_seq #(.AW(AW), .DW(DW), .CW(CW), .WE_LOW_CYC(WE_LOW),
                   .TMO_CYC(TMO), .SYNC_N(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base),
    .count_i(count), .wdata_i(wdata), .wvalid_i(wvalid), .wready_o(wready),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq), .fl_we_no(we_n),
    .fl_ready_i(fl_ready), .fl_fail_i(fl_fail), .busy_o(busy),
    .done_o(done), .error_o(error), .err_tmo_o(err_tmo), .err_addr_o(err_addr)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write log and device model
  logic [AW-1:0] log_a [MAXLOG];
  logic [DW-1:0] log_d [MAXLOG];
  int n_log = 0, cyc = 0, last_rise_cyc = -10, done_cnt = 0;
  int low_cnt = 0, pend = 0, bcnt = 0, word_idx = 0;
  int fail_word = -1, stuck_word = -1;
  bit prev_we = 1'b1, prev_done = 1'b0, hold_pend = 1'b0, dev_busy = 1'b0;
  bit hang = 1'b0;
  logic [AW-1:0] prev_a, fall_a, rise_a;
  logic [DW-1:0] prev_d, fall_d, rise_d, last_d = '0;

  always @(negedge clk) begin
    cyc++;
    if (hold_pend) begin
      chk(fl_addr == rise_a && fl_dq == rise_d, "R3 hold", fl_addr, rise_a);
      hold_pend = 1'b0;
    end
    if (prev_we && !we_n) begin
      chk(fl_addr == prev_a && fl_dq == prev_d, "R3 setup", fl_addr, prev_a);
      fall_a = fl_addr; fall_d = fl_dq; low_cnt = 0;
    end
    if (!we_n) low_cnt++;
    if (!prev_we && we_n) begin
      chk(low_cnt == WE_LOW, "R3 strobe width", low_cnt, WE_LOW);
      chk(fall_a == prev_a && fall_d == prev_d, "R3 stable low", prev_a, fall_a);
      rise_a = fl_addr; rise_d = fl_dq; hold_pend = 1'b1;
      if (fl_dq != 16'h00F0)
        chk(!dev_busy, "R4 write while busy", fl_dq, 0);
      if (n_log < MAXLOG) begin
        log_a[n_log] = fl_addr; log_d[n_log] = fl_dq;
      end
      n_log++;
      last_rise_cyc = cyc;
      if (fl_dq == 16'h00F0) begin
        fl_ready = 1'b1; fl_fail = 1'b0; dev_busy = 1'b0; pend = 0; hang = 1'b0;
      end else if (last_d == 16'h00A0) begin
        dev_busy = 1'b1; pend = 2;
        hang = (word_idx == fail_word) || (word_idx == stuck_word);
        fl_fail = 1'b0;
        if (word_idx == fail_word) fl_fail = 1'b0;
        word_idx++;
      end
      last_d = fl_dq;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        fl_ready = 1'b0; bcnt = BUSY_CYC;
        if (word_idx - 1 == fail_word) fl_fail = 1'b1;
      end
    end else if (!fl_ready && !hang) begin
      bcnt--;
      if (bcnt == 0) begin fl_ready = 1'b1; dev_busy = 1'b0; end
    end
    if (done) begin
      chk(!prev_done, "R5 done width", 1, 0);
      chk(cyc == last_rise_cyc + 1, "R5 done timing", cyc, last_rise_cyc + 1);
      done_cnt++;
    end
    prev_done = done; prev_we = we_n; prev_a = fl_addr; prev_d = fl_dq;
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(16'h3C00 + i * 16'h0111);
  endfunction

  task automatic feed(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) @(negedge clk);
      if (!busy) break;
      wvalid = 1'b1; wdata = pat(i);
      while (!wready && busy) @(negedge clk);
      @(negedge clk);
      wvalid = 1'b0;
      chk(!wready, "R9 word taken once", wready, 0);
    end
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  // runs one programming pass and checks the write log
  task automatic run(input string name, input logic [AW-1:0] b, input int n,
                     input int gap, input int fw, input int sw, input bit mid);
    int exp_n, pairs, dc0;
    logic [AW-1:0] xa;
    @(negedge clk);
    n_log = 0; word_idx = 0; last_d = '0;
    fail_word = fw; stuck_word = sw; dc0 = done_cnt;
    base = b; count = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R1 run accepted", busy, 1);
    chk(!error, "R12 error cleared at start", error, 0);
    fork
      feed(n, gap);
      begin
        if (mid) begin
          repeat (20) @(negedge clk);
          base = b ^ 20'h0F0F0; count = 16'd9; start = 1'b1;
          @(negedge clk);
          start = 1'b0;
          chk(busy, "R10 still busy", busy, 1);
        end
        wait_idle();
      end
    join
    base = b; count = CW'(n);
    if (fw >= 0) pairs = fw + 1;
    else if (sw >= 0) pairs = sw + 1;
    else pairs = n;
    exp_n = 3 + 2 * pairs + ((fw >= 0 || sw >= 0) ? 1 : 2);
    chk(n_log == exp_n, {name, " R10 R2 write count"}, n_log, exp_n);
    if (n_log == exp_n) begin
      chk(log_a[0] == 20'h555 && log_d[0] == 16'h00AA, "R1 unlock 1", log_d[0], 16'hAA);
      chk(log_a[1] == 20'h2AA && log_d[1] == 16'h0055, "R1 unlock 2", log_d[1], 16'h55);
      chk(log_a[2] == 20'h555 && log_d[2] == 16'h0020, "R1 bypass cmd", log_d[2], 16'h20);
      for (int i = 0; i < pairs; i++) begin
        xa = b + AW'(i);
        chk(log_d[3+2*i] == 16'h00A0, "R2 program cmd", log_d[3+2*i], 16'hA0);
        chk(log_a[4+2*i] == xa, "R2 target addr", log_a[4+2*i], xa);
        chk(log_d[4+2*i] == pat(i), "R2 R9 target data", log_d[4+2*i], pat(i));
      end
      if (fw >= 0 || sw >= 0) begin
        chk(log_d[exp_n-1] == 16'h00F0, "R7 R8 reset cmd", log_d[exp_n-1], 16'hF0);
      end else begin
        chk(log_d[exp_n-2] == 16'h0090, "R5 exit 1", log_d[exp_n-2], 16'h90);
        chk(log_d[exp_n-1] == 16'h0000, "R5 exit 2", log_d[exp_n-1], 16'h00);
      end
    end
    if (fw >= 0 || sw >= 0) begin
      xa = b + AW'(pairs - 1);
      chk(error, "R7 R8 error raised", error, 1);
      chk(err_addr == xa, "R7 R8 failing addr", err_addr, xa);
      chk(err_tmo == (sw >= 0), "R7 R8 timeout flag", err_tmo, sw >= 0);
      chk(done_cnt == dc0, "R7 no done", done_cnt, dc0);
    end else begin
      chk(!error, "R5 no error", error, 0);
      chk(done_cnt == dc0 + 1, "R5 R6 one done", done_cnt, dc0 + 1);
    end
    chk(!done, "R5 done cleared", done, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(we_n && !busy && !done && !error && !wready, "R11 reset state",
        {we_n, busy, done, error, wready}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(we_n && !busy && !wready, "R11 after release", {we_n, busy, wready}, 3'b100);
  endtask

  initial begin
    t_reset();
    run("basic", 20'h00100, 3, 0, -1, -1, 1'b0);
    run("cross", 20'h0FFFE, 4, 3, -1, -1, 1'b0);   // R2 crosses 64K word line
    run("zero", 20'h00200, 0, 0, -1, -1, 1'b0);    // R6
    run("fail", 20'h01000, 4, 0, 1, -1, 1'b0);     // R7
    run("tmo", 20'h02000, 3, 0, -1, 0, 1'b0);      // R8
    run("after_err", 20'h03000, 2, 1, -1, -1, 1'b0); // R12
    run("mid_start", 20'h04000, 3, 2, -1, -1, 1'b1); // R10
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule